// File: doc/BRIEF.md
# Port Output Stage with Address Routing and Quasi-Bidirectional Drive

This block is the output stage of two 8-bit microcontroller I/O ports whose pins can also carry external memory address bits. On every oscillator clock it picks, pin by pin, whether the pin shows the port's latch value or an address bit. It then registers that choice and produces three drive controls per pin: a strong pull-up enable, a weak pull-up enable and a pull-down enable. Together these controls imitate a quasi-bidirectional pin. A pin that holds 1 is pulled up weakly, so an outside device can pull it low and the pin can then be read as an input. A pin that has just gone from 0 to 1 gets a short burst of strong pull-up first.

Two things control the routing. A strap decides whether the low address byte may leave on the first port. For the upper address bits, a width flag must be set, and the external-access strap must be low or a configuration enable bit must be set. The seventh-bit pin of the second port has no internal pull-up, so its weak pull-up enable is never raised. The CPU bus cycle generator and the analog pads lie outside this block.

Top module: `port_addr_mux`

## Requirements
- R1: Port A (`pa_pin`) shows `mem_addr[7:0]` when `acc_active` and `lo_addr_strap` are both high. Otherwise it shows `pa_latch`.
- R2: Port B bits [7:1] show `mem_addr[14:8]` when three conditions hold: `acc_active` is high, `addr_wide` is high, and either `ext_strap` is low or `cfg_addr_en` is high. Otherwise these bits show `pb_latch[7:1]`.
- R3: Port B bit 0 always shows `pb_latch[0]`, including during address routing.
- R4: A pin value is registered. It appears on the pin outputs one clock after the inputs that select it.
- R5: When a pin goes from 0 to 1, its strong pull-up enable is high for exactly BURST clocks (default 2). It then drops, and from that point the weak pull-up enable is high for as long as the pin stays 1.
- R6: A pin that stays at 1 keeps weak pull-up only and gets no new burst. A pin that falls and then rises again, even in the middle of a burst, starts a full new burst.
- R7: A pin at 0 has its pull-down enable high and both pull-up enables low. A pin at 1 has its pull-down enable low.
- R8: Port B bit 7 never has its weak pull-up enable high.
- R9: While `rst_n` is low, all pins are 1, no burst is running, and weak pull-up is enabled on every pin except port B bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pa_latch | input | 8 | Port A latch value |
| pb_latch | input | 8 | Port B latch value |
| mem_addr | input | 15 | External memory address |
| acc_active | input | 1 | External access in progress |
| addr_wide | input | 1 | Address is 15 bits wide |
| lo_addr_strap | input | 1 | Strap allowing low address byte on port A |
| ext_strap | input | 1 | External-access strap |
| cfg_addr_en | input | 1 | Configuration enable for high address with strap high |
| pa_pin | output | 8 | Port A pin value |
| pa_pu_strong | output | 8 | Port A strong pull-up enables |
| pa_pu_weak | output | 8 | Port A weak pull-up enables |
| pa_pd | output | 8 | Port A pull-down enables |
| pb_pin | output | 8 | Port B pin value |
| pb_pu_strong | output | 8 | Port B strong pull-up enables |
| pb_pu_weak | output | 8 | Port B weak pull-up enables |
| pb_pd | output | 8 | Port B pull-down enables |

## Verification
Some rules are checked by assertions on every cycle:
- R1 with the strap low.
- R2 in its strap-low routing case.
- R3.
- The pull-down rule (R7), the start of a burst on each rise and an upper bound on burst length (R5).
- R8.

Other behaviour can only be shown by the bench's scenarios, which compare every pin and drive control against a reference model:
- The exact moment the strong pull-up hands over to weak pull-up.
- A burst restarting when a pin falls and rises again within it.
- The strap-high routing with the configuration bit set, and the cases where routing is refused.
- The reset state.

// File: rtl/pam_pkg.sv
package pam_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 15;

    typedef struct packed {
        logic acc_active;
        logic addr_wide;
        logic lo_addr_strap;
        logic ext_strap;
        logic cfg_addr_en;
    } route_ctl_t;
endpackage

// File: rtl/pam_route.sv
module pam_route
    import pam_pkg::*;
#(
    parameter int W  = PORT_W,
    parameter int AW = ADDR_W
) (
    input  route_ctl_t    ctl,
    input  logic [W-1:0]  pa_latch,
    input  logic [W-1:0]  pb_latch,
    input  logic [AW-1:0] mem_addr,
    output logic [W-1:0]  pa_sel,
    output logic [W-1:0]  pb_sel
);
    localparam int HI_W = AW - W;

    logic lo_route;
    logic hi_route;

    always_comb begin
        lo_route = ctl.acc_active && ctl.lo_addr_strap;
        hi_route = ctl.acc_active && ctl.addr_wide &&
                   (!ctl.ext_strap || ctl.cfg_addr_en);
        pa_sel   = lo_route ? mem_addr[W-1:0] : pa_latch;
        pb_sel   = pb_latch;
        if (hi_route) begin
            pb_sel[W-1:W-HI_W] = mem_addr[AW-1:W];
        end
    end

    // Port B bit 0 is always taken from the latch.
    always_comb begin
        AST_PB0_LATCH: assert (pb_sel[0] == pb_latch[0]); // R3
    end
endmodule

// File: rtl/pam_drive.sv
module pam_drive #(
    parameter int           W         = 8,
    parameter int           BURST     = 2,
    parameter logic [W-1:0] NOPU_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sel,
    output logic [W-1:0] pin,
    output logic [W-1:0] pu_strong,
    output logic [W-1:0] pu_weak,
    output logic [W-1:0] pd
);
    localparam int CW = $clog2(BURST + 1);
    localparam logic [CW-1:0] BURST_LD = CW'(BURST);

    typedef struct packed {
        logic [W-1:0]         pin;
        logic [W-1:0][CW-1:0] cnt;
    } drv_st_t;

    drv_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < W; i++) begin
            st_d.pin[i] = sel[i];
            if (!sel[i]) begin
                st_d.cnt[i] = '0;
            end else if (!st_q.pin[i]) begin
                st_d.cnt[i] = BURST_LD;
            end else if (st_q.cnt[i] != '0) begin
                st_d.cnt[i] = st_q.cnt[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pin <= '1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic burst_on;
        assign burst_on     = st_q.cnt[g] != '0;
        assign pin[g]       = st_q.pin[g];
        assign pu_strong[g] = st_q.pin[g] && burst_on;
        assign pu_weak[g]   = st_q.pin[g] && !burst_on && !NOPU_MASK[g];
        assign pd[g]        = !st_q.pin[g];

        logic [CW:0] run_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q <= '0;
            end else if (pu_strong[g]) begin
                run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
            end
        end

        AST_LOW_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
            !pin[g] |-> (pd[g] && !pu_strong[g] && !pu_weak[g])); // R7
        AST_RISE_STRONG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pin[g]) |-> pu_strong[g]); // R5
        AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            pu_strong[g] |-> (run_q < (CW+1)'(BURST))); // R5
        if (NOPU_MASK[g]) begin : g_nopu
            AST_NO_WEAK_PU: assert property (@(posedge clk) disable iff (!rst_n)
                !pu_weak[g]); // R8
        end
    end
endmodule

// File: rtl/port_addr_mux.sv
module port_addr_mux
    import pam_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int AW    = ADDR_W,
    parameter int BURST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  pa_latch,
    input  logic [W-1:0]  pb_latch,
    input  logic [AW-1:0] mem_addr,
    input  logic          acc_active,
    input  logic          addr_wide,
    input  logic          lo_addr_strap,
    input  logic          ext_strap,
    input  logic          cfg_addr_en,
    output logic [W-1:0]  pa_pin,
    output logic [W-1:0]  pa_pu_strong,
    output logic [W-1:0]  pa_pu_weak,
    output logic [W-1:0]  pa_pd,
    output logic [W-1:0]  pb_pin,
    output logic [W-1:0]  pb_pu_strong,
    output logic [W-1:0]  pb_pu_weak,
    output logic [W-1:0]  pb_pd
);
    localparam logic [W-1:0] PB_NOPU = {1'b1, {(W-1){1'b0}}};

    route_ctl_t   ctl;
    logic [W-1:0] pa_sel;
    logic [W-1:0] pb_sel;

    assign ctl = '{acc_active:    acc_active,
                   addr_wide:     addr_wide,
                   lo_addr_strap: lo_addr_strap,
                   ext_strap:     ext_strap,
                   cfg_addr_en:   cfg_addr_en};

    pam_route #(.W(W), .AW(AW)) u_route (
        .ctl      (ctl),
        .pa_latch (pa_latch),
        .pb_latch (pb_latch),
        .mem_addr (mem_addr),
        .pa_sel   (pa_sel),
        .pb_sel   (pb_sel)
    );

    pam_drive #(.W(W), .BURST(BURST), .NOPU_MASK('0)) u_drv_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (pa_sel),
        .pin       (pa_pin),
        .pu_strong (pa_pu_strong),
        .pu_weak   (pa_pu_weak),
        .pd        (pa_pd)
    );

    pam_drive #(.W(W), .BURST(BURST), .NOPU_MASK(PB_NOPU)) u_drv_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (pb_sel),
        .pin       (pb_pin),
        .pu_strong (pb_pu_strong),
        .pu_weak   (pb_pu_weak),
        .pd        (pb_pd)
    );

    AST_PA_STRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_addr_strap |=> pa_pin == $past(pa_latch)); // R1
    AST_PB_HI_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && addr_wide && !ext_strap) |=>
            pb_pin[W-1:1] == $past(mem_addr[AW-1:W])); // R2
    AST_PB0_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pb_pin[0] == $past(pb_latch[0])); // R3
endmodule

// File: tb/tb_port_addr_mux.sv
module tb_port_addr_mux;
    localparam int BURST = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pa_latch = 8'hFF, pb_latch = 8'hFF;
    logic [14:0] mem_addr = '0;
    logic        acc_active = 1'b0, addr_wide = 1'b0, lo_addr_strap = 1'b0;
    logic        ext_strap = 1'b0, cfg_addr_en = 1'b0;
    logic [7:0]  pa_pin, pa_pu_strong, pa_pu_weak, pa_pd;
    logic [7:0]  pb_pin, pb_pu_strong, pb_pu_weak, pb_pd;

    always #5 clk = ~clk;

    port_addr_mux #(.BURST(BURST)) dut (.*);

    typedef struct {
        logic [63:0] v;
        string       tag;
    } exp_t;

    exp_t    q[$];
    int      nvec = 0;
    int      nerr = 0;
    logic [15:0] m_pin;
    int      m_cnt[16];

    function automatic logic [63:0] model_out();
        logic [15:0] s, w, d;
        for (int i = 0; i < 16; i++) begin
            s[i] = m_pin[i] && (m_cnt[i] != 0);
            w[i] = m_pin[i] && (m_cnt[i] == 0) && (i != 15);
            d[i] = !m_pin[i];
        end
        return {m_pin[7:0], s[7:0], w[7:0], d[7:0],
                m_pin[15:8], s[15:8], w[15:8], d[15:8]};
    endfunction

    function automatic logic [63:0] dut_out();
        return {pa_pin, pa_pu_strong, pa_pu_weak, pa_pd,
                pb_pin, pb_pu_strong, pb_pu_weak, pb_pd};
    endfunction

    task automatic apply(input logic [7:0] a, input logic [7:0] b,
                         input logic [14:0] addr, input logic act,
                         input logic lo, input logic ea, input logic cfg,
                         input logic wide, input string tag);
        logic [15:0] sel;
        exp_t e;
        @(negedge clk);
        pa_latch = a; pb_latch = b; mem_addr = addr; acc_active = act;
        lo_addr_strap = lo; ext_strap = ea; cfg_addr_en = cfg; addr_wide = wide;
        sel[7:0]  = (act && lo) ? addr[7:0] : a;          // R1
        sel[15:8] = b;
        if (act && wide && (!ea || cfg)) sel[15:9] = addr[14:8]; // R2, R3
        for (int i = 0; i < 16; i++) begin
            if (!sel[i])          m_cnt[i] = 0;
            else if (!m_pin[i])   m_cnt[i] = BURST;
            else if (m_cnt[i] > 0) m_cnt[i] = m_cnt[i] - 1;
        end
        m_pin = sel;
        e.v = model_out();
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            nvec++;
            if (dut_out() !== e.v) begin
                nerr++;
                $display("FAIL %s actual=%h expected=%h", e.tag, dut_out(), e.v);
            end
        end
    end

    logic done = 1'b0;
    initial begin
        #1000000;
        if (!done) begin
            nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        m_pin = 16'hFFFF;
        for (int i = 0; i < 16; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        nvec++;
        if (dut_out() !== model_out()) begin
            nerr++;
            $display("FAIL R9 actual=%h expected=%h", dut_out(), model_out());
        end
        rst_n = 1'b1;
        // R7: drive zeros
        apply(8'h00, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R7");
        // R5: rising bits burst then weak; R4 one-clock latency
        apply(8'hA5, 8'h3C, 15'h0, 0, 0, 0, 0, 0, "R5/R4");
        apply(8'hA5, 8'h3C, 15'h0, 0, 0, 0, 0, 0, "R5");
        apply(8'hA5, 8'h3C, 15'h0, 0, 0, 0, 0, 0, "R5");
        apply(8'hA5, 8'h3C, 15'h0, 0, 0, 0, 0, 0, "R6");
        // R1/R2/R3: full routing, ext strap low
        apply(8'h11, 8'h01, 15'h5A96, 1, 1, 0, 0, 1, "R1/R2/R3");
        apply(8'h11, 8'h00, 15'h2B69, 1, 1, 0, 0, 1, "R3");
        // R1: strap low keeps latch
        apply(8'h3E, 8'h00, 15'h2B69, 1, 0, 0, 0, 1, "R1");
        // R2: ext strap high, cfg off -> latch; cfg on -> address
        apply(8'h3E, 8'h42, 15'h7FFF, 1, 0, 1, 0, 1, "R2");
        apply(8'h3E, 8'h42, 15'h7FFF, 1, 0, 1, 1, 1, "R2");
        // R2: not wide -> latch
        apply(8'h3E, 8'h42, 15'h7FFF, 1, 0, 1, 1, 0, "R2");
        apply(8'h3E, 8'h42, 15'h7FFF, 0, 1, 0, 1, 1, "R1/R2");
        // R6: fall and rise inside a burst restarts it
        apply(8'h00, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R7");
        apply(8'h01, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R5");
        apply(8'h00, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R6");
        apply(8'h01, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R6");
        apply(8'h01, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R6");
        apply(8'h01, 8'h00, 15'h0, 0, 0, 0, 0, 0, "R6");
        // R8: port B bit 7 high never weak
        apply(8'hFF, 8'h80, 15'h0, 0, 0, 0, 0, 0, "R8");
        apply(8'hFF, 8'h80, 15'h0, 0, 0, 0, 0, 0, "R8");
        apply(8'hFF, 8'h80, 15'h0, 0, 0, 0, 0, 0, "R8");
        apply(8'hFF, 8'hFF, 15'h0, 0, 0, 0, 0, 0, "R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule